// File: doc/BRIEF.md
# Precision-Time Port Timing Engine

This block is the timing core of one precision-time clock port. At startup it stays silent and waits for a Sync from another clock. If none comes within the listen window, it takes the master role. Otherwise it becomes a slave.

As master, it requests a Sync at a fixed interval. Each Sync is followed at once by a Follow_Up that carries the exact time the Sync was requested. The master also answers every Delay_Req with a Delay_Resp that carries the receive time of that request. When another master's Sync advertises a smaller timestamp than the local time, the port yields and becomes a slave.

As slave, it collects the four exchange stamps and computes offset and path delay. The stamps are: master send time t1, local receive time t2, local Delay_Req send time t3, and master receive time t4. The offset is then removed from the local nanosecond counter.

The engine consumes decoded message events and produces send requests. Framing, line coding and port arbitration sit outside it. Message kinds are encoded 0 = Sync, 1 = Follow_Up, 2 = Delay_Req, 3 = Delay_Resp. Roles are encoded 0 = listening, 1 = master, 2 = slave.

Top module: `ptp_slave_engine`

## Requirements
- R1: After reset the port reports role 0 and requests nothing. If no Sync arrives, role becomes 1 at the LISTEN_CYC-th clock edge after reset is released.
- R2: A Sync received while listening makes the role 2 at the next edge. That Sync is not used as a timing sample, and the role never returns to 0 until the next reset.
- R3: In role 1 a Sync request (kind 0) appears in the first master cycle and then every SYNC_CYC cycles. Its sequence number starts at 0 and rises by one per Sync, and its timestamp equals the local time in that cycle.
- R4: Every Sync request is followed in the next cycle by a Follow_Up request (kind 1) with the same sequence number and the same timestamp.
- R5: In role 1 a received Sync whose timestamp is smaller than the local time makes the role 2. A Sync with a timestamp not smaller than the local time leaves the role at 1.
- R6: In role 1 a received Delay_Req (kind 2) is answered by a Delay_Resp request (kind 3). The answer echoes the sequence number and carries the local time at reception. It is sent in the next cycle, or later if a Sync or Follow_Up request takes that cycle.
- R7: In role 2 the local time at a Sync's arrival is kept as t2. Only a Follow_Up whose sequence number equals that Sync's supplies t1, and its timestamp replaces the estimate in the Sync. A Follow_Up with another sequence number, or a second Follow_Up for the same Sync, is discarded and triggers nothing.
- R8: One cycle after an accepted Follow_Up, a Delay_Req request is made. Its sequence number starts at 0 and rises by one per request. Its timestamp is the local time in that cycle, and that time is kept as t3.
- R9: A Delay_Resp is accepted only when a Delay_Req is outstanding and the sequence numbers match. Any other Delay_Resp produces no offset strobe.
- R10: Two edges after an accepted Delay_Resp, offset_valid is high for one cycle. At that point offset = ((t2-t1)-(t4-t3))/2 and path_delay = ((t2-t1)+(t4-t3))/2, computed in signed 32-bit differences and halved with an arithmetic shift.
- R11: The local time starts at 0 and grows by NS_PER_CLK each cycle. In the cycle after the offset strobe it instead grows by NS_PER_CLK minus the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received message event present |
| rx_type | input | 2 | Kind of received message |
| rx_seq | input | 8 | Sequence number of received message |
| rx_ts | input | 32 | Timestamp carried in received message |
| tx_valid | output | 1 | Send request present |
| tx_type | output | 2 | Kind of message to send |
| tx_seq | output | 8 | Sequence number for the message to send |
| tx_ts | output | 32 | Timestamp to place in the message |
| role | output | 2 | Current role |
| local_time | output | 32 | Corrected local time in ns |
| offset | output | 32 | Last computed offset, signed |
| path_delay | output | 32 | Last computed path delay, signed |
| offset_valid | output | 1 | One-cycle strobe for new offset and delay |

## Verification
The assertions watch the cycle-level invariants on every cycle:
- silence while listening;
- Follow_Up pairing with the preceding Sync;
- each request kind coming only from its proper role;
- the one-cycle offset strobe;
- the exact growth of the local time with and without a correction.

Only the bench's scenarios can show the rest:
- the listen timeout count and the Sync interval count;
- the best-master decision for a smaller or larger advertised stamp;
- Delay_Resp postponement behind a Sync/Follow_Up pair;
- rejection of mismatched, stale and unsolicited Follow_Up and Delay_Resp messages;
- the signed offset and delay arithmetic over a sweep of stamp patterns where the slave is behind and ahead.

// File: rtl/ptp_eng_pkg.sv
`timescale 1ns/1ps
package ptp_eng_pkg;

    localparam int TS_W  = 32;
    localparam int SEQ_W = 8;

    typedef logic [TS_W-1:0]  stamp_t;
    typedef logic [SEQ_W-1:0] seq_t;

    typedef enum logic [1:0] {
        MSG_SYNC   = 2'd0,
        MSG_FOLLOW = 2'd1,
        MSG_DREQ   = 2'd2,
        MSG_DRESP  = 2'd3
    } msg_t;

    typedef enum logic [1:0] {
        ROLE_LISTEN = 2'd0,
        ROLE_MASTER = 2'd1,
        ROLE_SLAVE  = 2'd2
    } role_t;

    typedef struct packed {
        logic   valid;
        msg_t   kind;
        seq_t   seq;
        stamp_t ts;
    } msg_ev_t;

    typedef struct packed {
        stamp_t t1;
        stamp_t t2;
        stamp_t t3;
        stamp_t t4;
    } quad_t;

    // Halve a signed value one bit wider than a stamp, keep stamp width.
    function automatic stamp_t half_of(input logic signed [TS_W:0] v);
        logic signed [TS_W:0] h;
        h = v >>> 1;
        return h[TS_W-1:0];
    endfunction

    // Sign-extend a stamp difference by one bit.
    function automatic logic signed [TS_W:0] widen(input stamp_t d);
        return $signed({d[TS_W-1], d});
    endfunction

endpackage

// File: rtl/ptp_role_ctrl.sv
`timescale 1ns/1ps
module ptp_role_ctrl
    import ptp_eng_pkg::*;
#(
    parameter int LISTEN_CYC = 64,
    parameter int SYNC_CYC   = 32
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   foreign_sync,
    input  stamp_t foreign_ts,
    input  stamp_t now,
    output role_t  role,
    output logic   sync_fire
);

    localparam int LW = $clog2(LISTEN_CYC + 1);
    localparam int SW = $clog2(SYNC_CYC + 1);

    logic [LW-1:0] listen_cnt;
    logic [SW-1:0] sync_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            role       <= ROLE_LISTEN;
            listen_cnt <= '0;
            sync_cnt   <= '0;
        end else begin
            case (role)
                ROLE_LISTEN: begin
                    if (foreign_sync)
                        role <= ROLE_SLAVE;
                    else if (listen_cnt == LW'(LISTEN_CYC - 1))
                        role <= ROLE_MASTER;
                    else
                        listen_cnt <= listen_cnt + 1'b1;
                end
                ROLE_MASTER: begin
                    if (sync_cnt == '0)
                        sync_cnt <= SW'(SYNC_CYC - 1);
                    else
                        sync_cnt <= sync_cnt - 1'b1;
                    // best master: the smaller advertised stamp wins
                    if (foreign_sync && (foreign_ts < now))
                        role <= ROLE_SLAVE;
                end
                default: role <= role;
            endcase
        end
    end

    assign sync_fire = (role == ROLE_MASTER) && (sync_cnt == '0);

endmodule

// File: rtl/ptp_msg_exchange.sv
`timescale 1ns/1ps
module ptp_msg_exchange
    import ptp_eng_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  role_t   role,
    input  logic    sync_fire,
    input  msg_ev_t rx,
    input  stamp_t  now,
    output msg_ev_t tx,
    output quad_t   stamps,
    output logic    calc_go
);

    typedef enum logic [2:0] {
        SEL_NONE, SEL_FOL, SEL_SYNC, SEL_DREQ, SEL_DRESP
    } sel_t;

    quad_t  q;
    seq_t   rx_sync_seq;
    logic   have_sync;
    logic   dreq_pend, dreq_out;
    seq_t   dreq_ctr, dreq_seq;
    seq_t   sync_ctr, fol_seq;
    stamp_t fol_ts;
    logic   fol_pend;
    logic   resp_pend;
    seq_t   resp_seq;
    stamp_t resp_ts;
    sel_t   sel;

    logic is_slave, is_master;
    assign is_slave  = (role == ROLE_SLAVE);
    assign is_master = (role == ROLE_MASTER);

    always_comb begin
        if (fol_pend)                    sel = SEL_FOL;
        else if (sync_fire)              sel = SEL_SYNC;
        else if (dreq_pend && is_slave)  sel = SEL_DREQ;
        else if (resp_pend && is_master) sel = SEL_DRESP;
        else                             sel = SEL_NONE;
    end

    always_comb begin
        tx = '0;
        case (sel)
            SEL_FOL:   tx = '{valid: 1'b1, kind: MSG_FOLLOW, seq: fol_seq,  ts: fol_ts};
            SEL_SYNC:  tx = '{valid: 1'b1, kind: MSG_SYNC,   seq: sync_ctr, ts: now};
            SEL_DREQ:  tx = '{valid: 1'b1, kind: MSG_DREQ,   seq: dreq_ctr, ts: now};
            SEL_DRESP: tx = '{valid: 1'b1, kind: MSG_DRESP,  seq: resp_seq, ts: resp_ts};
            default:   tx = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q           <= '0;
            rx_sync_seq <= '0;
            have_sync   <= 1'b0;
            dreq_pend   <= 1'b0;
            dreq_out    <= 1'b0;
            dreq_ctr    <= '0;
            dreq_seq    <= '0;
            sync_ctr    <= '0;
            fol_seq     <= '0;
            fol_ts      <= '0;
            fol_pend    <= 1'b0;
            resp_pend   <= 1'b0;
            resp_seq    <= '0;
            resp_ts     <= '0;
            calc_go     <= 1'b0;
        end else begin
            calc_go <= 1'b0;

            // transmit side bookkeeping
            case (sel)
                SEL_FOL:  fol_pend <= 1'b0;
                SEL_SYNC: begin
                    fol_pend <= 1'b1;
                    fol_ts   <= now;
                    fol_seq  <= sync_ctr;
                    sync_ctr <= sync_ctr + 1'b1;
                end
                SEL_DREQ: begin
                    dreq_pend <= 1'b0;
                    dreq_out  <= 1'b1;
                    dreq_seq  <= dreq_ctr;
                    dreq_ctr  <= dreq_ctr + 1'b1;
                    q.t3      <= now;
                end
                SEL_DRESP: resp_pend <= 1'b0;
                default: ;
            endcase

            // slave receive side
            if (is_slave && rx.valid) begin
                case (rx.kind)
                    MSG_SYNC: begin
                        q.t2        <= now;
                        rx_sync_seq <= rx.seq;
                        have_sync   <= 1'b1;
                    end
                    MSG_FOLLOW: begin
                        if (have_sync && (rx.seq == rx_sync_seq)) begin
                            q.t1      <= rx.ts;
                            have_sync <= 1'b0;
                            dreq_pend <= 1'b1;
                        end
                    end
                    MSG_DRESP: begin
                        if (dreq_out && (rx.seq == dreq_seq)) begin
                            q.t4     <= rx.ts;
                            dreq_out <= 1'b0;
                            calc_go  <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end

            // master receive side
            if (is_master && rx.valid && (rx.kind == MSG_DREQ)) begin
                resp_pend <= 1'b1;
                resp_seq  <= rx.seq;
                resp_ts   <= now;
            end
        end
    end

    assign stamps = q;

endmodule

// File: rtl/ptp_offset_calc.sv
`timescale 1ns/1ps
module ptp_offset_calc
    import ptp_eng_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   calc_go,
    input  quad_t  q,
    output stamp_t offset,
    output stamp_t path_delay,
    output logic   valid
);

    stamp_t d_ms, d_sm;
    logic signed [TS_W:0] s_dif, s_sum;

    always_comb begin
        d_ms  = q.t2 - q.t1;
        d_sm  = q.t4 - q.t3;
        s_dif = widen(d_ms) - widen(d_sm);
        s_sum = widen(d_ms) + widen(d_sm);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            offset     <= '0;
            path_delay <= '0;
            valid      <= 1'b0;
        end else begin
            valid <= calc_go;
            if (calc_go) begin
                offset     <= half_of(s_dif);
                path_delay <= half_of(s_sum);
            end
        end
    end

endmodule

// File: rtl/ptp_local_clock.sv
`timescale 1ns/1ps
module ptp_local_clock
    import ptp_eng_pkg::*;
#(
    parameter int NS_PER_CLK = 10
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   corr_valid,
    input  stamp_t corr,
    output stamp_t now
);

    localparam stamp_t STEP = stamp_t'(NS_PER_CLK);

    always_ff @(posedge clk) begin
        if (rst)
            now <= '0;
        else if (corr_valid)
            now <= now + STEP - corr;
        else
            now <= now + STEP;
    end

endmodule

// File: rtl/ptp_slave_engine.sv
`timescale 1ns/1ps
module ptp_slave_engine
    import ptp_eng_pkg::*;
#(
    parameter int LISTEN_CYC = 64,
    parameter int SYNC_CYC   = 32,
    parameter int NS_PER_CLK = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_valid,
    input  logic [1:0]       rx_type,
    input  logic [SEQ_W-1:0] rx_seq,
    input  logic [TS_W-1:0]  rx_ts,
    output logic             tx_valid,
    output logic [1:0]       tx_type,
    output logic [SEQ_W-1:0] tx_seq,
    output logic [TS_W-1:0]  tx_ts,
    output logic [1:0]       role,
    output logic [TS_W-1:0]  local_time,
    output logic [TS_W-1:0]  offset,
    output logic [TS_W-1:0]  path_delay,
    output logic             offset_valid
);

    msg_ev_t rx_ev, tx_ev;
    role_t   role_q;
    logic    sync_fire, calc_go, foreign_sync;
    quad_t   stamps;
    stamp_t  now, offs;

    assign rx_ev        = '{valid: rx_valid, kind: msg_t'(rx_type), seq: rx_seq, ts: rx_ts};
    assign foreign_sync = rx_valid && (msg_t'(rx_type) == MSG_SYNC);

    ptp_role_ctrl #(
        .LISTEN_CYC (LISTEN_CYC),
        .SYNC_CYC   (SYNC_CYC)
    ) u_role (
        .clk          (clk),
        .rst          (rst),
        .foreign_sync (foreign_sync),
        .foreign_ts   (rx_ts),
        .now          (now),
        .role         (role_q),
        .sync_fire    (sync_fire)
    );

    ptp_msg_exchange u_xchg (
        .clk       (clk),
        .rst       (rst),
        .role      (role_q),
        .sync_fire (sync_fire),
        .rx        (rx_ev),
        .now       (now),
        .tx        (tx_ev),
        .stamps    (stamps),
        .calc_go   (calc_go)
    );

    ptp_offset_calc u_calc (
        .clk        (clk),
        .rst        (rst),
        .calc_go    (calc_go),
        .q          (stamps),
        .offset     (offs),
        .path_delay (path_delay),
        .valid      (offset_valid)
    );

    ptp_local_clock #(
        .NS_PER_CLK (NS_PER_CLK)
    ) u_clock (
        .clk        (clk),
        .rst        (rst),
        .corr_valid (offset_valid),
        .corr       (offs),
        .now        (now)
    );

    assign tx_valid   = tx_ev.valid;
    assign tx_type    = tx_ev.kind;
    assign tx_seq     = tx_ev.seq;
    assign tx_ts      = tx_ev.ts;
    assign role       = role_q;
    assign local_time = now;
    assign offset     = offs;

endmodule

// File: rtl/ptp_slave_engine_chk.sv
`timescale 1ns/1ps
module ptp_slave_engine_chk
    import ptp_eng_pkg::*;
#(
    parameter int NS_PER_CLK = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             tx_valid,
    input logic [1:0]       tx_type,
    input logic [SEQ_W-1:0] tx_seq,
    input logic [TS_W-1:0]  tx_ts,
    input logic [1:0]       role,
    input logic [TS_W-1:0]  local_time,
    input logic [TS_W-1:0]  offset,
    input logic             offset_valid
);

    // R1
    listen_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (role == ROLE_LISTEN) |-> !tx_valid);

    // R2
    no_relisten_chk: assert property (@(posedge clk) disable iff (rst)
        (role != ROLE_LISTEN) |=> (role != ROLE_LISTEN));

    // R3
    sync_stamp_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_type == MSG_SYNC) |-> (role == ROLE_MASTER && tx_ts == local_time));

    // R4
    follow_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_type == MSG_FOLLOW) |->
            ($past(tx_valid && tx_type == MSG_SYNC) && tx_seq == $past(tx_seq) && tx_ts == $past(tx_ts)));

    // R6
    resp_role_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_type == MSG_DRESP) |-> (role == ROLE_MASTER));

    // R8
    dreq_role_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_type == MSG_DREQ) |-> (role == ROLE_SLAVE && tx_ts == local_time));

    // R10
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        offset_valid |=> !offset_valid);

    // R11
    time_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(offset_valid)) |->
            (local_time == $past(local_time) + TS_W'(NS_PER_CLK)));

    // R11
    time_corr_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(offset_valid)) |->
            (local_time == $past(local_time) + TS_W'(NS_PER_CLK) - $past(offset)));

endmodule

bind ptp_slave_engine ptp_slave_engine_chk #(.NS_PER_CLK(NS_PER_CLK)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .tx_valid     (tx_valid),
    .tx_type      (tx_type),
    .tx_seq       (tx_seq),
    .tx_ts        (tx_ts),
    .role         (role),
    .local_time   (local_time),
    .offset       (offset),
    .offset_valid (offset_valid)
);

// File: tb/ptp_slave_engine_tb.sv
`timescale 1ns/1ps
module ptp_slave_engine_tb;

    localparam int LISTEN = 64;
    localparam int SYNCI  = 32;
    localparam int NS     = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic [1:0]  rx_type = 2'd0;
    logic [7:0]  rx_seq = 8'd0;
    logic [31:0] rx_ts = 32'd0;
    logic        tx_valid;
    logic [1:0]  tx_type;
    logic [7:0]  tx_seq;
    logic [31:0] tx_ts;
    logic [1:0]  role;
    logic [31:0] local_time, offset, path_delay;
    logic        offset_valid;

    int n_run  = 0;
    int n_fail = 0;
    int m      = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    ptp_slave_engine #(.LISTEN_CYC(LISTEN), .SYNC_CYC(SYNCI), .NS_PER_CLK(NS)) u_dut (
        .clk(clk), .rst(rst),
        .rx_valid(rx_valid), .rx_type(rx_type), .rx_seq(rx_seq), .rx_ts(rx_ts),
        .tx_valid(tx_valid), .tx_type(tx_type), .tx_seq(tx_seq), .tx_ts(tx_ts),
        .role(role), .local_time(local_time), .offset(offset),
        .path_delay(path_delay), .offset_valid(offset_valid)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        m++;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        rx_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m = 0;
    endtask

    // present one received message for one edge
    task automatic send(input logic [1:0] kind, input logic [7:0] seq, input logic [31:0] ts);
        rx_valid = 1'b1;
        rx_type  = kind;
        rx_seq   = seq;
        rx_ts    = ts;
        step();
        rx_valid = 1'b0;
    endtask

    function automatic logic [31:0] half_calc(input logic [31:0] t1, t2, t3, t4, input bit add);
        int a, b;
        longint s;
        a = int'(t2 - t1);
        b = int'(t4 - t3);
        s = add ? (longint'(a) + longint'(b)) : (longint'(a) - longint'(b));
        s = s >>> 1;
        return s[31:0];
    endfunction

    function automatic bit is_tx(input logic [1:0] kind, input logic [7:0] seq, input logic [31:0] ts);
        return tx_valid && tx_type == kind && tx_seq == seq && tx_ts == ts;
    endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] t1, t2, t3, t4, tm, eo, ed;
        logic [7:0]  dseq;

        // ---------------- master scenario ----------------
        do_reset();
        chk(role == 2'd0, "R1", "reset role", role, 0);
        chk(!tx_valid, "R1", "reset tx", tx_valid, 0);
        chk(local_time == 0, "R11", "reset time", local_time, 0);
        for (int k = 1; k < LISTEN; k++) begin
            step();
            chk(role == 2'd0 && !tx_valid, "R1", "listen silent", {role, tx_valid}, 0);
            chk(local_time == 32'(NS * k), "R11", "time step", local_time, NS * k);
        end
        step();
        chk(role == 2'd1, "R1", "timeout to master", role, 1);
        chk(is_tx(2'd0, 8'd0, 32'(NS * LISTEN)), "R3", "first sync", tx_ts, NS * LISTEN);
        step();
        chk(is_tx(2'd1, 8'd0, 32'(NS * LISTEN)), "R4", "first follow", tx_ts, NS * LISTEN);
        for (int i = 1; i <= 3; i++) begin
            for (int k = 0; k < SYNCI - 2; k++) begin
                step();
                chk(!tx_valid, "R3", "quiet between syncs", tx_valid, 0);
            end
            step();
            tm = 32'(NS * (LISTEN + SYNCI * i));
            chk(is_tx(2'd0, 8'(i), tm), "R3", "periodic sync", {tx_type, tx_seq, tx_ts}, {2'd0, 8'(i), tm});
            step();
            chk(is_tx(2'd1, 8'(i), tm), "R4", "periodic follow", {tx_type, tx_seq, tx_ts}, {2'd1, 8'(i), tm});
        end
        step();
        t4 = local_time;
        send(2'd2, 8'h55, 32'h0);
        chk(is_tx(2'd3, 8'h55, t4), "R6", "delay resp", {tx_type, tx_seq, tx_ts}, {2'd3, 8'h55, t4});
        while (m < LISTEN + SYNCI * 4) step();
        chk(is_tx(2'd0, 8'd4, local_time), "R3", "sync at collision", tx_seq, 4);
        t4 = local_time;
        send(2'd2, 8'h66, 32'h0);
        chk(is_tx(2'd1, 8'd4, t4), "R4", "follow before resp", tx_type, 1);
        step();
        chk(is_tx(2'd3, 8'h66, t4), "R6", "postponed resp", {tx_type, tx_seq, tx_ts}, {2'd3, 8'h66, t4});
        step();
        send(2'd0, 8'h01, 32'hFFFF_FFF0);
        chk(role == 2'd1, "R5", "keep master on larger stamp", role, 1);
        send(2'd0, 8'h02, 32'd5);
        chk(role == 2'd2, "R5", "yield on smaller stamp", role, 2);

        // ---------------- slave scenario ----------------
        do_reset();
        while (m < 5) step();
        send(2'd0, 8'h07, 32'h1234);
        chk(role == 2'd2, "R2", "sync in listen gives slave", role, 2);
        send(2'd1, 8'h07, 32'h100);
        chk(!tx_valid, "R2", "role-change sync not sampled", tx_valid, 0);
        send(2'd3, 8'h00, 32'h100);
        chk(!offset_valid, "R9", "unsolicited resp", offset_valid, 0);
        step();
        chk(!offset_valid, "R9", "unsolicited resp later", offset_valid, 0);
        dseq = 8'd0;
        for (int i = 0; i < 6; i++) begin
            t2 = local_time;
            send(2'd0, 8'(10 + i), 32'h0BAD_0000);
            t1 = t2 - 32'(i * 1234) + 32'd400;
            send(2'd1, 8'(11 + i), t1);
            chk(!tx_valid, "R7", "mismatched follow", tx_valid, 0);
            send(2'd1, 8'(10 + i), t1);
            chk(tx_valid && tx_type == 2'd2 && tx_seq == dseq && tx_ts == local_time,
                "R8", "delay req", {tx_type, tx_seq}, {2'd2, dseq});
            t3 = tx_ts;
            send(2'd1, 8'(10 + i), t1);
            chk(!tx_valid, "R7", "stale follow", tx_valid, 0);
            t4 = t3 + 32'(i * 777) + 32'd90;
            send(2'd3, dseq + 8'd1, t4);
            chk(!offset_valid, "R9", "mismatched resp", offset_valid, 0);
            step();
            chk(!offset_valid, "R9", "mismatched resp later", offset_valid, 0);
            send(2'd3, dseq, t4);
            chk(!offset_valid, "R10", "strobe not early", offset_valid, 0);
            step();
            eo = half_calc(t1, t2, t3, t4, 1'b0);
            ed = half_calc(t1, t2, t3, t4, 1'b1);
            chk(offset_valid, "R10", "strobe", offset_valid, 1);
            chk(offset == eo, "R10", "offset", offset, eo);
            chk(path_delay == ed, "R10", "delay", path_delay, ed);
            tm = local_time;
            step();
            chk(local_time == tm + 32'(NS) - eo, "R11", "corrected time", local_time, tm + 32'(NS) - eo);
            chk(!offset_valid, "R10", "strobe one cycle", offset_valid, 0);
            dseq = dseq + 8'd1;
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule